// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that completes one instruction per clock. On each rising edge it executes the instruction word at the current program counter. That work covers fetching the word from a private instruction store and decoding it. It then reads two general registers, runs one ALU operation, may touch a private data store, writes one result back and advances an 8-bit, word-counting program counter. The supported instructions are the R-type arithmetic and logic group, add-immediate, word load, word store, branch-if-equal, and a register-indexed load. The register-indexed load fetches the data word at address `rs - rt` into `rd`.

Both stores hold 256 words of 32 bits. They are filled through a load port while the core is held in reset. Three combinational debug ports let a bench inspect the state: one shows a chosen register, and the other two show the instruction word and data word at a chosen address. The program counter is also visible as an output. Programs end by branching to themselves.

Top module: `scc_core`

## Requirements
- R1: A synchronous `rst` sets `pc` to 0. While `rst` or `loadEn` is 1, `pc` does not advance and no register or data-store write from the core takes place.
- R2: With no taken branch, `pc` becomes `pc + 1` (modulo 256) on every clock edge.
- R3: beq (opcode 000100) is taken when the subtract ALU result of `rs` and `rt` is zero. A taken branch sets `pc` to `pc + 1 + imm[7:0]` (modulo 256); otherwise `pc` becomes `pc + 1`.
- R4: R-type (opcode 000000) writes `rd` with the result selected by funct: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 100111 NOR, 101010 set-less-than.
- R5: Set-less-than compares both operands as signed 32-bit values and yields exactly 1 or 0.
- R6: addi (opcode 001000) writes `rt` with `rs` plus the 16-bit immediate sign-extended from bit 15.
- R7: lw (100011) loads data word `(rs + sext(imm))[7:0]` into `rt`. sw (101011) stores `rt` to that word and writes no register.
- R8: The register-indexed load (opcode 000001, fields rs/rt/rd in R-type positions) loads data word `(rs - rt)[7:0]` into `rd` and writes no memory.
- R9: Register 0 always reads as 0, and writes to it are ignored.
- R10: An unrecognised opcode, or an R-type word with an unlisted funct, changes no register and no data word.
- R11: With `loadEn` = 1, each clock edge writes `loadWord` to word `loadAddr` of the data store when `loadToData` = 1, or of the instruction store otherwise. The debug outputs follow their select inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the program counter |
| loadEn | input | 1 | Preload strobe; freezes execution while 1 |
| loadToData | input | 1 | Preload target: 1 data store, 0 instruction store |
| loadAddr | input | 8 | Preload word address |
| loadWord | input | 32 | Preload data |
| dbgRegSel | input | 5 | Register to show on `dbgRegVal` |
| dbgRegVal | output | 32 | Contents of the selected register |
| dbgMemSel | input | 8 | Word address to show on the memory debug outputs |
| dbgDataWord | output | 32 | Data store word at `dbgMemSel` |
| dbgInstrWord | output | 32 | Instruction store word at `dbgMemSel` |
| pc | output | 8 | Current program counter |

## Verification
The embedded assertions check, on every cycle, the rules that do not depend on arithmetic. These are the reset value of the counter, its step by one or by the branch offset, and the landing of register and data-store writes at the addressed slot. They also check that decode never pairs a store with a writeback and that undecoded words stay inert. Only the bench can show arithmetic correctness and the signed ordering of set-less-than. The bench runs a fixed program over a sweep of operand pairs that includes the signed extremes and equal pairs. It then compares each result register and the stored word against values computed independently. The same runs show that the branch skips exactly one word when its operands are equal and falls through otherwise.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int INSTR_W = 32;

  typedef struct packed {
    logic       regDst;
    logic       aluSrc;
    logic       memToReg;
    logic       regWrite;
    logic       memWrite;
    logic       memRead;
    logic       branch;
    logic [3:0] aluCtl;
  } ctlStrobes_t;

  localparam logic [3:0] ALU_AND = 4'd0;
  localparam logic [3:0] ALU_OR  = 4'd1;
  localparam logic [3:0] ALU_ADD = 4'd2;
  localparam logic [3:0] ALU_SUB = 4'd6;
  localparam logic [3:0] ALU_SLT = 4'd7;
  localparam logic [3:0] ALU_NOR = 4'd12;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LWR   = 6'b000001;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctlStrobes_t ctl
);

  logic knownOp;

  always_comb begin
    ctl     = '0;
    knownOp = 1'b1;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctl.aluCtl = ALU_ADD;
          FN_SUB:  ctl.aluCtl = ALU_SUB;
          FN_AND:  ctl.aluCtl = ALU_AND;
          FN_OR:   ctl.aluCtl = ALU_OR;
          FN_NOR:  ctl.aluCtl = ALU_NOR;
          FN_SLT:  ctl.aluCtl = ALU_SLT;
          default: begin
            ctl.regWrite = 1'b0;
            knownOp      = 1'b0;
          end
        endcase
      end
      OP_LWR: begin
        ctl.regDst   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.memRead  = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluCtl   = ALU_SUB;
      end
      OP_ADDI: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluCtl   = ALU_ADD;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.memRead  = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluCtl   = ALU_ADD;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
        ctl.aluCtl   = ALU_ADD;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aluCtl = ALU_SUB;
      end
      default: knownOp = 1'b0;
    endcase
  end

  AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> !ctl.regWrite && !ctl.branch); // R7
  AST_UNDECODED_INERT: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> !ctl.regWrite && !ctl.memWrite && !ctl.branch); // R10
  AST_INDEXED_LOAD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_LWR) |-> ctl.regDst && !ctl.aluSrc && ctl.memToReg && !ctl.memWrite); // R8

endmodule

// File: rtl/scc_regbank.sv
module scc_regbank #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [RA_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RA_W-1:0]   rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [RA_W-1:0]   rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [RA_W-1:0]   rdAddrDbg,
  output logic [DATA_W-1:0] rdDataDbg
);

  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA   = (rdAddrA   == '0) ? '0 : regs[rdAddrA];
  assign rdDataB   = (rdAddrB   == '0) ? '0 : regs[rdAddrB];
  assign rdDataDbg = (rdAddrDbg == '0) ? '0 : regs[rdAddrDbg];

  AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> regs[$past(wrAddr)] == $past(wrData)); // R4
  AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn && wrAddr == '0) |-> rdDataDbg == '0 || rdAddrDbg != '0); // R9

endmodule

// File: rtl/scc_wordmem.sv
module scc_wordmem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddrA,
  output logic [DATA_W-1:0] rDataA,
  input  logic [ADDR_W-1:0] rAddrB,
  output logic [DATA_W-1:0] rDataB
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
  end

  // port A is the execution read port and honours the active-low select
  assign rDataA = csN ? '0 : cells[rAddrA];
  assign rDataB = cells[rAddrB];

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> cells[$past(wAddr)] == $past(wData)); // R7

endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [PC_W-1:0]   loadAddr,
  input  logic [DATA_W-1:0] loadWord,
  input  ctlStrobes_t       ctl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  input  logic [RA_W-1:0]   dbgRegSel,
  output logic [DATA_W-1:0] dbgRegVal,
  input  logic [PC_W-1:0]   dbgMemSel,
  output logic [DATA_W-1:0] dbgDataWord,
  output logic [DATA_W-1:0] dbgInstrWord,
  output logic [PC_W-1:0]   pc
);

  logic [PC_W-1:0]    pcQ, nextPc, brOffset;
  logic [INSTR_W-1:0] instr;
  logic [RA_W-1:0]    rsIdx, rtIdx, rdIdx, wrIdx;
  logic [15:0]        imm;
  logic [DATA_W-1:0]  immExt, rsVal, rtVal, aluB, aluOut, memRd, wbData;
  logic [DATA_W-1:0]  dmemWData;
  logic [PC_W-1:0]    dmemWAddr;
  logic               aluZero, takeBr, dmemWe, imemWe, coreRun;

  assign coreRun = !loadEn && !rst;

  // fetch and field split
  scc_wordmem #(.ADDR_W(PC_W), .DATA_W(INSTR_W)) imem_i (
    .clk(clk), .rst(rst), .csN(loadEn), .we(imemWe),
    .wAddr(loadAddr), .wData(loadWord),
    .rAddrA(pcQ), .rDataA(instr),
    .rAddrB(dbgMemSel), .rDataB(dbgInstrWord)
  );
  assign imemWe = loadEn && !loadToData;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign imm    = instr[15:0];
  assign immExt = {{(DATA_W-16){imm[15]}}, imm};

  // register operands
  assign wrIdx  = ctl.regDst ? rdIdx : rtIdx;
  assign wbData = (ctl.memToReg && ctl.memRead) ? memRd : aluOut;

  scc_regbank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) regs_i (
    .clk(clk), .rst(rst),
    .wrEn(ctl.regWrite && coreRun), .wrAddr(wrIdx), .wrData(wbData),
    .rdAddrA(rsIdx), .rdDataA(rsVal),
    .rdAddrB(rtIdx), .rdDataB(rtVal),
    .rdAddrDbg(dbgRegSel), .rdDataDbg(dbgRegVal)
  );

  // ALU
  assign aluB = ctl.aluSrc ? immExt : rtVal;

  always_comb begin
    unique case (ctl.aluCtl)
      ALU_AND: aluOut = rsVal & aluB;
      ALU_OR:  aluOut = rsVal | aluB;
      ALU_ADD: aluOut = rsVal + aluB;
      ALU_SUB: aluOut = rsVal - aluB;
      ALU_SLT: aluOut = ($signed(rsVal) < $signed(aluB)) ? DATA_W'(1) : '0;
      ALU_NOR: aluOut = ~(rsVal | aluB);
      default: aluOut = '0;
    endcase
  end
  assign aluZero = (aluOut == '0);

  // data store: preload port has priority over core stores
  assign dmemWe    = loadEn ? loadToData : (ctl.memWrite && !rst);
  assign dmemWAddr = loadEn ? loadAddr : aluOut[PC_W-1:0];
  assign dmemWData = loadEn ? loadWord : rtVal;

  scc_wordmem #(.ADDR_W(PC_W), .DATA_W(DATA_W)) dmem_i (
    .clk(clk), .rst(rst), .csN(1'b0), .we(dmemWe),
    .wAddr(dmemWAddr), .wData(dmemWData),
    .rAddrA(aluOut[PC_W-1:0]), .rDataA(memRd),
    .rAddrB(dbgMemSel), .rDataB(dbgDataWord)
  );

  // next PC
  assign takeBr   = ctl.branch && aluZero;
  assign brOffset = takeBr ? immExt[PC_W-1:0] : '0;
  assign nextPc   = pcQ + PC_W'(1) + brOffset;

  always_ff @(posedge clk) begin
    if (rst)          pcQ <= '0;
    else if (!loadEn) pcQ <= nextPc;
  end
  assign pc = pcQ;

  AST_PC_CLEARED: assert property (@(posedge clk)
    rst |=> pcQ == '0); // R1
  AST_PC_FROZEN_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> $stable(pcQ)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !takeBr) |=> pcQ == PC_W'($past(pcQ) + 1)); // R2
  AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && takeBr) |=> pcQ == PC_W'($past(pcQ) + 1 + $past(immExt[PC_W-1:0]))); // R3
  AST_SLT_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluCtl == ALU_SLT) |-> aluOut[DATA_W-1:1] == '0); // R5

endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [PC_W-1:0]   loadAddr,
  input  logic [DATA_W-1:0] loadWord,
  input  logic [RA_W-1:0]   dbgRegSel,
  output logic [DATA_W-1:0] dbgRegVal,
  input  logic [PC_W-1:0]   dbgMemSel,
  output logic [DATA_W-1:0] dbgDataWord,
  output logic [DATA_W-1:0] dbgInstrWord,
  output logic [PC_W-1:0]   pc
);

  ctlStrobes_t ctl;
  logic [5:0]  opcode, funct;

  scc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .ctl(ctl)
  );

  scc_datapath #(.PC_W(PC_W), .DATA_W(DATA_W), .REG_CNT(REG_CNT)) dp_i (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadWord(loadWord), .ctl(ctl),
    .opcode(opcode), .funct(funct),
    .dbgRegSel(dbgRegSel), .dbgRegVal(dbgRegVal),
    .dbgMemSel(dbgMemSel), .dbgDataWord(dbgDataWord),
    .dbgInstrWord(dbgInstrWord), .pc(pc)
  );

endmodule

// File: tb/scc_core_tb.sv
`timescale 1ns/1ps
module scc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst, loadEn, loadToData;
  logic [7:0]  loadAddr, dbgMemSel, pc;
  logic [31:0] loadWord, dbgRegVal, dbgDataWord, dbgInstrWord;
  logic [4:0]  dbgRegSel;
  int          checkCnt = 0;
  int          failCnt  = 0;
  logic [31:0] prog [21];

  always #2 clk = ~clk;

  scc_core dut_i (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadWord(loadWord),
    .dbgRegSel(dbgRegSel), .dbgRegVal(dbgRegVal),
    .dbgMemSel(dbgMemSel), .dbgDataWord(dbgDataWord),
    .dbgInstrWord(dbgInstrWord), .pc(pc)
  );

  function automatic logic [31:0] rType(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction

  function automatic logic [31:0] iType(logic [5:0] op, int rs, int rt, logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkReg(string tag, int r, logic [31:0] exp);
    dbgRegSel = 5'(r);
    #0.1;
    check(tag, dbgRegVal, exp);
  endtask

  task automatic checkMem(string tag, int a, logic [31:0] exp);
    dbgMemSel = 8'(a);
    #0.1;
    check(tag, dbgDataWord, exp);
  endtask

  task automatic loadOne(logic toData, int a, logic [31:0] w);
    loadToData = toData;
    loadAddr   = 8'(a);
    loadWord   = w;
    @(negedge clk);
  endtask

  task automatic runCase(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] sltExp;
    rst = 1'b1;
    loadEn = 1'b1;
    for (int i = 0; i < 21; i++) loadOne(1'b0, i, prog[i]);
    loadOne(1'b1, 0, a);
    loadOne(1'b1, 1, b);
    loadOne(1'b1, 2, 32'h0);
    loadOne(1'b1, 3, c);
    loadEn = 1'b0;
    @(negedge clk);
    check("R1 pc after reset", {24'b0, pc}, 32'd0);
    dbgMemSel = 8'd17;
    #0.1;
    check("R11 instruction preload", dbgInstrWord, prog[17]);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 pc step", {24'b0, pc}, 32'd5);
    repeat (30) @(negedge clk);
    sltExp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    check("R3 halt loop pc", {24'b0, pc}, 32'd20);
    checkReg("R7 lw word 0", 1, a);
    checkReg("R4 add", 3, a + b);
    checkReg("R4 sub", 4, a - b);
    checkReg("R4 and", 5, a & b);
    checkReg("R4 or", 6, a | b);
    checkReg("R5 signed slt", 7, sltExp);
    checkReg("R4 nor", 8, ~(a | b));
    checkReg("R6 addi negative / R10 undecoded", 9, 32'hFFFF_FFFB);
    checkReg("R8 indexed load", 13, c);
    checkReg("R9 zero register", 0, 32'd0);
    checkReg("R3 branch skip", 14, (a == b) ? 32'd0 : 32'd1);
    checkReg("R3 branch target", 15, 32'd2);
    checkMem("R7 sw", 2, a + b);
    checkMem("R8 no store", 3, c);
    checkMem("R11 data preload", 0, a);
  endtask

  initial begin
    logic [31:0] vals [6];
    rst = 1'b1; loadEn = 1'b0; loadToData = 1'b0; loadAddr = '0; loadWord = '0;
    dbgRegSel = '0; dbgMemSel = '0;
    vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    prog[0]  = iType(6'b100011, 0, 1, 16'd0);        // lw $1,0($0)
    prog[1]  = iType(6'b100011, 0, 2, 16'd1);        // lw $2,1($0)
    prog[2]  = rType(1, 2, 3, 6'b100000);            // add
    prog[3]  = rType(1, 2, 4, 6'b100010);            // sub
    prog[4]  = rType(1, 2, 5, 6'b100100);            // and
    prog[5]  = rType(1, 2, 6, 6'b100101);            // or
    prog[6]  = rType(1, 2, 7, 6'b101010);            // slt
    prog[7]  = rType(1, 2, 8, 6'b100111);            // nor
    prog[8]  = iType(6'b001000, 0, 9, 16'hFFFB);     // addi $9,$0,-5
    prog[9]  = iType(6'b101011, 0, 3, 16'd2);        // sw $3,2($0)
    prog[10] = iType(6'b001000, 0, 11, 16'd5);
    prog[11] = iType(6'b001000, 0, 12, 16'd2);
    prog[12] = {6'b000001, 5'd11, 5'd12, 5'd13, 11'd0}; // $13 = mem[5-2]
    prog[13] = iType(6'b001000, 0, 0, 16'd9);        // write to $0
    prog[14] = rType(1, 2, 9, 6'b111111);            // unlisted funct
    prog[15] = iType(6'b111111, 1, 9, 16'h1234);     // unrecognised opcode
    prog[16] = iType(6'b001000, 0, 14, 16'd0);
    prog[17] = iType(6'b000100, 1, 2, 16'd1);        // beq $1,$2,+1
    prog[18] = iType(6'b001000, 0, 14, 16'd1);
    prog[19] = iType(6'b001000, 0, 15, 16'd2);
    prog[20] = iType(6'b000100, 0, 0, 16'hFFFF);     // self loop
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        runCase(vals[i], vals[j], 32'hA5A5_0000 + 32'(i * 6 + j));
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #800000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%h expected=%h", pc, 8'd20);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule